// File: doc/BRIEF.md
# Program Counter Sequencer

This block owns the 15-bit instruction address register of a small 8-bit controller core. On every clock it picks the next address from a fixed set of sources: the reset vector, the interrupt vector, a direct reload of the low byte, an absolute jump or call, a signed relative branch, a plain increment, or no change. A 15-bit address reaches 32K instruction words.

A separate 7-bit high-address latch supplies the upper address bits for two kinds of update. A write to the low byte takes all of its upper bits from the latch. An absolute jump or call takes only its top four bits from the latch. The latch is an ordinary register. It changes only when software writes it and never follows the program counter. On a call or an accepted interrupt, the block offers the address of the following instruction and a push strobe to an external return stack. Decode, program memory and the stack storage are outside this block.

Top module: `pc_sequencer`

## Requirements
- R1: While rst_ni is low, pc_o reads 0x0000, lat_o reads 0x00 and push_o is 0.
- R2: With adv_i as the only active request, pc_o becomes pc_o+1 modulo 2^15 at the next edge, so 0x7FFF wraps to 0x0000.
- R3: When irq_i is high, pc_o becomes 0x0004 at the next edge, whatever the other requests are. In that same cycle push_o is 1 and ret_addr_o is pc_o+1 modulo 2^15.
- R4: When pcl_we_i is high and irq_i is low, the next pc_o is {lat_o[6:0], pcl_wdata_i[7:0]}. The latch value used is the one held before the edge, even if lat_we_i is high in the same cycle.
- R5: When jmp_i is high and no higher-priority request is active, the next pc_o is {lat_o[6:3], jmp_imm_i[10:0]}.
- R6: call_i loads the same target as a jump. In the cycle the call is accepted, push_o is 1 and ret_addr_o is pc_o+1 modulo 2^15.
- R7: When br_i is high and no higher-priority request is active, the next pc_o is pc_o+1 plus br_off_i (two's complement, 9 bits, sign-extended), modulo 2^15.
- R8: Priority from highest to lowest is irq_i, pcl_we_i, jmp_i/call_i, br_i, adv_i. push_o is 0 unless a call or interrupt is actually accepted.
- R9: With no request active, pc_o keeps its value.
- R10: pcl_o always equals pc_o[7:0]. lat_o shows the last value written through lat_we_i and does not change when pc_o changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt accepted this cycle |
| adv_i | input | 1 | Advance to next instruction |
| jmp_i | input | 1 | Absolute jump request |
| call_i | input | 1 | Absolute call request |
| jmp_imm_i | input | 11 | Jump/call immediate target |
| br_i | input | 1 | Relative branch request |
| br_off_i | input | 9 | Signed branch offset |
| pcl_we_i | input | 1 | Write strobe for low address byte |
| pcl_wdata_i | input | 8 | Low address byte write data |
| lat_we_i | input | 1 | Write strobe for high-address latch |
| lat_wdata_i | input | 7 | High-address latch write data |
| pc_o | output | 15 | Current program counter |
| pcl_o | output | 8 | Low byte of the program counter |
| lat_o | output | 7 | High-address latch contents |
| ret_addr_o | output | 15 | Return address for the external stack |
| push_o | output | 1 | Push the return address this cycle |

## Verification
The next-address choice is driven with each request on its own, and then with pairs and larger sets of requests active together. The single-source cases show that each source's target arithmetic is correct. The combined cases show the priority order and that a lower-priority call does not push. Branches are tried with positive and negative offsets and across both ends of the address space, which separates correct sign extension and modulo wrap from truncation. Low-byte writes are made with the latch written in the same cycle, which shows that the old latch value is used. Jumps are made with latch patterns whose low three bits differ from their high bits, which shows that only latch bits 6:3 reach the target.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int unsigned PC_W    = 15;
  localparam int unsigned LO_W    = 8;
  localparam int unsigned LAT_W   = PC_W - LO_W;
  localparam int unsigned IMM_W   = 11;
  localparam int unsigned OFF_W   = 9;
  localparam int unsigned JHI_W   = PC_W - IMM_W;
  localparam logic [PC_W-1:0] RST_VEC = '0;
  localparam logic [PC_W-1:0] IRQ_VEC = PC_W'(4);

  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_INC,
    SEL_BR,
    SEL_JMP,
    SEL_PCL,
    SEL_IRQ
  } pc_sel_e;
endpackage

// File: rtl/pc_seq_arb.sv
module pc_seq_arb
  import pc_seq_pkg::*;
(
  input  logic    irq_i,
  input  logic    pcl_we_i,
  input  logic    jmp_i,
  input  logic    call_i,
  input  logic    br_i,
  input  logic    adv_i,
  output pc_sel_e sel_o,
  output logic    push_o
);
  always_comb begin
    if (irq_i)                sel_o = SEL_IRQ;
    else if (pcl_we_i)        sel_o = SEL_PCL;
    else if (jmp_i || call_i) sel_o = SEL_JMP;
    else if (br_i)            sel_o = SEL_BR;
    else if (adv_i)           sel_o = SEL_INC;
    else                      sel_o = SEL_HOLD;
  end

  assign push_o = (sel_o == SEL_IRQ) || ((sel_o == SEL_JMP) && call_i);
endmodule

// File: rtl/pc_seq_next.sv
module pc_seq_next
  import pc_seq_pkg::*;
(
  input  pc_sel_e          sel_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic [LO_W-1:0]  pcl_wdata_i,
  input  logic [IMM_W-1:0] jmp_imm_i,
  input  logic [OFF_W-1:0] br_off_i,
  output logic [PC_W-1:0]  pc_inc_o,
  output logic [PC_W-1:0]  pc_nxt_o
);
  logic [PC_W-1:0] off_sx;
  logic [PC_W-1:0] br_tgt;

  assign pc_inc_o = pc_i + PC_W'(1);
  assign off_sx   = {{(PC_W-OFF_W){br_off_i[OFF_W-1]}}, br_off_i};
  assign br_tgt   = pc_inc_o + off_sx;  // wraps modulo 2^PC_W

  always_comb begin
    unique case (sel_i)
      SEL_IRQ: pc_nxt_o = IRQ_VEC;
      SEL_PCL: pc_nxt_o = {lat_i, pcl_wdata_i};
      SEL_JMP: pc_nxt_o = {lat_i[LAT_W-1 -: JHI_W], jmp_imm_i};
      SEL_BR:  pc_nxt_o = br_tgt;
      SEL_INC: pc_nxt_o = pc_inc_o;
      default: pc_nxt_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_i,
  input  logic             adv_i,
  input  logic             jmp_i,
  input  logic             call_i,
  input  logic [IMM_W-1:0] jmp_imm_i,
  input  logic             br_i,
  input  logic [OFF_W-1:0] br_off_i,
  input  logic             pcl_we_i,
  input  logic [LO_W-1:0]  pcl_wdata_i,
  input  logic             lat_we_i,
  input  logic [LAT_W-1:0] lat_wdata_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [LO_W-1:0]  pcl_o,
  output logic [LAT_W-1:0] lat_o,
  output logic [PC_W-1:0]  ret_addr_o,
  output logic             push_o
);
  pc_sel_e          sel;
  logic [PC_W-1:0]  pc_q, pc_nxt, pc_inc;
  logic [LAT_W-1:0] lat_q;

  pc_seq_arb u_arb (
    .irq_i    (irq_i),
    .pcl_we_i (pcl_we_i),
    .jmp_i    (jmp_i),
    .call_i   (call_i),
    .br_i     (br_i),
    .adv_i    (adv_i),
    .sel_o    (sel),
    .push_o   (push_o)
  );

  pc_seq_next u_next (
    .sel_i       (sel),
    .pc_i        (pc_q),
    .lat_i       (lat_q),
    .pcl_wdata_i (pcl_wdata_i),
    .jmp_imm_i   (jmp_imm_i),
    .br_off_i    (br_off_i),
    .pc_inc_o    (pc_inc),
    .pc_nxt_o    (pc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RST_VEC;
    else         pc_q <= pc_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lat_q <= '0;
    else if (lat_we_i) lat_q <= lat_wdata_i;
  end

  assign pc_o       = pc_q;
  assign pcl_o      = pc_q[LO_W-1:0];
  assign lat_o      = lat_q;
  assign ret_addr_o = pc_inc;

  AST_IRQ_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> pc_o == IRQ_VEC); // R3
  AST_PCL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_i && pcl_we_i) |=> pc_o == {$past(lat_o), $past(pcl_wdata_i)}); // R4
  AST_INC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !irq_i && !pcl_we_i && !jmp_i && !call_i && !br_i)
      |=> pc_o == $past(pc_o) + PC_W'(1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !irq_i && !pcl_we_i && !jmp_i && !call_i && !br_i)
      |=> $stable(pc_o)); // R9
  AST_PUSH_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (irq_i || (call_i && !pcl_we_i))); // R8
  AST_LAT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat_we_i |=> $stable(lat_o)); // R10
endmodule

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 0, adv = 0, jmp = 0, call = 0, br = 0, pcl_we = 0, lat_we = 0;
  logic [10:0] imm = '0;
  logic [8:0]  off = '0;
  logic [7:0]  pcl_wd = '0;
  logic [6:0]  lat_wd = '0;
  logic [14:0] pc, ret;
  logic [7:0]  pcl;
  logic [6:0]  lat;
  logic        push;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_sequencer u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .adv_i(adv), .jmp_i(jmp),
    .call_i(call), .jmp_imm_i(imm), .br_i(br), .br_off_i(off),
    .pcl_we_i(pcl_we), .pcl_wdata_i(pcl_wd), .lat_we_i(lat_we),
    .lat_wdata_i(lat_wd), .pc_o(pc), .pcl_o(pcl), .lat_o(lat),
    .ret_addr_o(ret), .push_o(push)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    {irq, adv, jmp, call, br, pcl_we, lat_we} = '0;
  endtask

  // apply current inputs for one edge, then clear them
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic set_pc(logic [14:0] v);
    lat_we = 1; lat_wd = v[14:8]; step();
    pcl_we = 1; pcl_wd = v[7:0]; step();
  endtask

  task automatic t_reset();
    chk("R1 pc", pc, 0);
    chk("R1 lat", lat, 0);
    chk("R1 push", push, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_adv();
    adv = 1; step(); chk("R2 inc", pc, 15'h0001);
    set_pc(15'h7FFF);
    adv = 1; step(); chk("R2 wrap", pc, 15'h0000);
    step(); chk("R9 hold", pc, 15'h0000);
    step(); chk("R9 hold2", pc, 15'h0000);
  endtask

  task automatic t_pcl();
    set_pc(15'h1234);
    chk("R4 load", pc, 15'h1234);
    chk("R10 pcl", pcl, 8'h34);
    lat_we = 1; lat_wd = 7'h55; pcl_we = 1; pcl_wd = 8'hAB; step();
    chk("R4 old latch", pc, 15'h12AB);
    chk("R10 lat new", lat, 7'h55);
    adv = 1; step(); step();
    chk("R10 lat stays", lat, 7'h55);
  endtask

  task automatic t_jump();
    lat_we = 1; lat_wd = 7'b1010_111; step();
    jmp = 1; imm = 11'h2A5; #1;
    chk("R8 jmp nopush", push, 0);
    step(); chk("R5 jump", pc, {4'b1010, 11'h2A5});
  endtask

  task automatic t_call();
    set_pc(15'h0456);
    lat_we = 1; lat_wd = 7'b0101_000; step();
    call = 1; imm = 11'h7FF; #1;
    chk("R6 push", push, 1);
    chk("R6 ret", ret, 15'h0457);
    step(); chk("R6 target", pc, {4'b0101, 11'h7FF});
  endtask

  task automatic t_branch();
    set_pc(15'h0100);
    br = 1; off = 9'h010; step(); chk("R7 fwd", pc, 15'h0111);
    br = 1; off = 9'h1F0; step(); chk("R7 back", pc, 15'h0102);
    set_pc(15'h0002);
    br = 1; off = 9'h100; step(); chk("R7 wrap low", pc, 15'h7F03);
    set_pc(15'h7FF0);
    br = 1; off = 9'h0FF; step(); chk("R7 wrap high", pc, 15'h00F0);
  endtask

  task automatic t_irq();
    set_pc(15'h7FFF);
    irq = 1; pcl_we = 1; pcl_wd = 8'h11; jmp = 1; call = 1; br = 1; adv = 1; #1;
    chk("R3 push", push, 1);
    chk("R3 ret", ret, 15'h0000);
    step(); chk("R3 vector", pc, 15'h0004);
  endtask

  task automatic t_prio();
    lat_we = 1; lat_wd = 7'h3C; step();
    pcl_we = 1; pcl_wd = 8'h77; call = 1; imm = 11'h001; br = 1; adv = 1; #1;
    chk("R8 pcl over call nopush", push, 0);
    step(); chk("R8 pcl wins", pc, 15'h3C77);
    jmp = 1; imm = 11'h123; br = 1; off = 9'h005; adv = 1; step();
    chk("R8 jmp over br", pc, {4'b0111, 11'h123});
    br = 1; off = 9'h1FE; adv = 1; step();
    chk("R8 br over adv", pc, {4'b0111, 11'h122});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    t_reset();
    t_adv();
    t_pcl();
    t_jump();
    t_call();
    t_branch();
    t_irq();
    t_prio();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule